// File: doc/BRIEF.md
# Asynchronous Slave FIFO Read Port

This block is the read side of a small multi-queue FIFO that an external master reads through pins that carry no clock. The master picks one of several queues with a select field and qualifies the access with a chip select. An output enable decides whether the data pins are driven, and a read strobe pulls words out. All of these pins are active-low. The block samples them into its own clock domain through two-stage synchronisers. It then decides three things: whether the data pins are driven, which word they carry, and when a queue's read pointer moves. A simple write port fills the queues from the internal side.

Output enable and the read strobe are separate controls. Enable on its own re-presents the word that is already held. The falling strobe loads the head word of the selected queue into the holding register. The pointer moves only when the strobe is released, so a word is always shown before it is consumed. The two pins may be wired together. An active-low empty flag reports on the queue that is selected now.

The data output and its drive-enable feed a tri-state pad outside the block. When the drive-enable is low, the pad is high-impedance.

Top module: `async_fifo_rdport`

## Requirements
- R1: After a synchronous reset, the drive-enable is low, the shown word is 0 and the empty flag is low (all queues empty).
- R2: The drive-enable is high exactly when both chip select and output enable, after two clock stages of synchronisation, are low. The read strobe does not affect it.
- R3: When output enable is asserted with no read strobe, the pins show the word already held (0 after reset). It is not a fresh queue word.
- R4: A read starts only on a falling read strobe while chip select was already low for at least one synchronised cycle before. If the strobe and chip select fall together, or the strobe falls with chip select high, no word is loaded and no pointer moves.
- R5: A started read on a non-empty queue loads that queue's head word into the shown word three clock edges after the strobe pin falls.
- R6: Each strobe pulse on a non-empty queue advances that queue's read pointer by exactly one, on the strobe's release, so a burst of pulses shows consecutive words.
- R7: A strobe on an empty queue leaves every pointer unchanged and keeps the previously shown word.
- R8: The queue select is captured when the read starts. Changing it while the strobe is held does not change which queue advances on release.
- R9: The empty flag is high when the queue named by the synchronised select holds at least one word. It reflects counts and the select one clock edge later.
- R10: Each queue holds 16 words of 16 bits. A write to a full queue is dropped.
- R11: With output enable and the read strobe driven as one signal, single and burst reads show the same words as with separate pins.
- R12: Four queues, chosen by select values 0 to 3, fill and drain independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_sel_i | input | 2 | Queue select from the master (asynchronous) |
| cs_n_i | input | 1 | Chip select, active low (asynchronous) |
| oe_n_i | input | 1 | Output enable, active low (asynchronous) |
| rd_n_i | input | 1 | Read strobe, active low (asynchronous) |
| wr_en_i | input | 1 | Internal write request |
| wr_sel_i | input | 2 | Queue receiving the write |
| wr_data_i | input | 16 | Write word |
| data_o | output | 16 | Word presented to the tri-state pad |
| data_drive_o | output | 1 | Pad drive-enable; low means high-impedance |
| empty_n_o | output | 1 | Empty flag of the selected queue, active low |

## Verification
The bench holds the strobe pins for several cycles on each step and compares every output to a queue-based model on every clock. It aims at the ordering of show and consume: a design that advanced the pointer on the strobe's leading edge would show each word one position late in a burst. It also covers a strobe that arrives together with chip select, which a careless start condition would accept and so lose a word. It checks a strobe on a drained queue: a design that moved the pointer anyway would skip the next word written. It changes the select mid-strobe, which would drain the wrong queue if the select were not latched. Tied enable and strobe reads and an overfilled queue round out the corner cases.

// File: rtl/rdport_pkg.sv
package rdport_pkg;

    localparam int WORD_W_DEF = 16;
    localparam int DEPTH_DEF  = 16;
    localparam int NFIFO_DEF  = 4;

    // Control pins after polarity correction: 1 means asserted.
    typedef struct packed {
        logic cs;
        logic oe;
        logic rd;
    } strobe_t;

    // Read transaction state.
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,  // no read under way
        RS_SHOW = 2'd1,  // word loaded, pointer moves on release
        RS_DRY  = 2'd2   // strobe on an empty queue, nothing to consume
    } rstate_e;

    function automatic strobe_t decode_pins(input logic cs_n, input logic oe_n,
                                            input logic rd_n);
        strobe_t s;
        s.cs = ~cs_n;
        s.oe = ~oe_n;
        s.rd = ~rd_n;
        return s;
    endfunction

endpackage

// File: rtl/rdport_sync.sv
module rdport_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

endmodule

// File: rtl/rdport_ctrl.sv
module rdport_ctrl
    import rdport_pkg::*;
#(
    parameter  int NFIFO = 4,
    localparam int SEL_W = (NFIFO > 1) ? $clog2(NFIFO) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  strobe_t          act,
    input  logic [SEL_W-1:0] sel_s,
    input  logic [NFIFO-1:0] empty_vec,
    output logic             load,
    output logic [SEL_W-1:0] load_sel,
    output logic [NFIFO-1:0] pop_vec
);

    rstate_e          state;
    logic             rd_prev;
    logic             cs_prev;
    logic [SEL_W-1:0] sel_l;
    logic             start;
    logic             release_edge;

    // Chip select must already have been seen before the strobe edge.
    assign start        = act.rd & ~rd_prev & act.cs & cs_prev;
    assign release_edge = ~act.rd & rd_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev <= 1'b0;
            cs_prev <= 1'b0;
            state   <= RS_IDLE;
            sel_l   <= '0;
        end else begin
            rd_prev <= act.rd;
            cs_prev <= act.cs;
            case (state)
                RS_IDLE: begin
                    if (start) begin
                        sel_l <= sel_s;
                        state <= empty_vec[sel_s] ? RS_DRY : RS_SHOW;
                    end
                end
                RS_SHOW, RS_DRY: begin
                    if (release_edge) state <= RS_IDLE;
                end
                default: state <= RS_IDLE;
            endcase
        end
    end

    assign load     = (state == RS_IDLE) & start & ~empty_vec[sel_s];
    assign load_sel = sel_s;

    for (genvar g = 0; g < NFIFO; g++) begin : g_pop
        assign pop_vec[g] = (state == RS_SHOW) & release_edge & (sel_l == SEL_W'(g));
    end

    AST_SINGLE_POP: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pop_vec)); // R6

    AST_NO_POP_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
        act.rd |-> (pop_vec == '0)); // R6

endmodule

// File: rtl/rdport_store.sv
module rdport_store #(
    parameter  int NFIFO  = 4,
    parameter  int WORD_W = 16,
    parameter  int DEPTH  = 16,
    localparam int SEL_W  = (NFIFO > 1) ? $clog2(NFIFO) : 1,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic [NFIFO-1:0]             pop_vec,
    output logic [NFIFO-1:0][WORD_W-1:0] heads,
    output logic [NFIFO-1:0]             empty_vec
);

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar g = 0; g < NFIFO; g++) begin : g_fifo
        logic [WORD_W-1:0] mem [DEPTH];
        logic [PTR_W-1:0]  rptr;
        logic [PTR_W-1:0]  wptr;
        logic [CNT_W-1:0]  cnt;
        logic              push;
        logic              pop;

        assign push = wr_en & (wr_sel == SEL_W'(g)) & (cnt < CNT_W'(DEPTH));
        assign pop  = pop_vec[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                rptr <= '0;
                wptr <= '0;
                cnt  <= '0;
            end else begin
                if (push) wptr <= step(wptr);
                if (pop)  rptr <= step(rptr);
                case ({push, pop})
                    2'b10:   cnt <= cnt + 1'b1;
                    2'b01:   cnt <= cnt - 1'b1;
                    default: cnt <= cnt;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (push) mem[wptr] <= wr_data;
        end

        assign heads[g]     = mem[rptr];
        assign empty_vec[g] = (cnt == '0);

        AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
            pop |-> (cnt != '0)); // R7

        AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
            cnt <= CNT_W'(DEPTH)); // R10
    end

endmodule

// File: rtl/async_fifo_rdport.sv
module async_fifo_rdport
    import rdport_pkg::*;
#(
    parameter  int NFIFO  = NFIFO_DEF,
    parameter  int WORD_W = WORD_W_DEF,
    parameter  int DEPTH  = DEPTH_DEF,
    localparam int SEL_W  = (NFIFO > 1) ? $clog2(NFIFO) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  fifo_sel_i,
    input  logic              cs_n_i,
    input  logic              oe_n_i,
    input  logic              rd_n_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] data_o,
    output logic              data_drive_o,
    output logic              empty_n_o
);

    localparam int PIN_W = 3 + SEL_W;
    localparam logic [PIN_W-1:0] PIN_IDLE = {3'b111, {SEL_W{1'b0}}};

    logic [PIN_W-1:0]             pins_s;
    strobe_t                      act;
    logic [SEL_W-1:0]             sel_s;
    logic [NFIFO-1:0]             empty_vec;
    logic [NFIFO-1:0]             pop_vec;
    logic [NFIFO-1:0][WORD_W-1:0] heads;
    logic                         load;
    logic [SEL_W-1:0]             load_sel;
    logic [WORD_W-1:0]            shown_q;
    logic                         empty_n_q;

    rdport_sync #(.W(PIN_W), .RST_VAL(PIN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n_i, oe_n_i, rd_n_i, fifo_sel_i}),
        .q   (pins_s)
    );

    assign act   = decode_pins(pins_s[SEL_W+2], pins_s[SEL_W+1], pins_s[SEL_W]);
    assign sel_s = pins_s[SEL_W-1:0];

    rdport_ctrl #(.NFIFO(NFIFO)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .sel_s     (sel_s),
        .empty_vec (empty_vec),
        .load      (load),
        .load_sel  (load_sel),
        .pop_vec   (pop_vec)
    );

    rdport_store #(.NFIFO(NFIFO), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en_i),
        .wr_sel    (wr_sel_i),
        .wr_data   (wr_data_i),
        .pop_vec   (pop_vec),
        .heads     (heads),
        .empty_vec (empty_vec)
    );

    // Holding register: the word on the pins between reads.
    always_ff @(posedge clk) begin
        if (rst) begin
            shown_q   <= '0;
            empty_n_q <= 1'b0;
        end else begin
            if (load) shown_q <= heads[load_sel];
            empty_n_q <= ~empty_vec[sel_s];
        end
    end

    assign data_o       = shown_q;
    assign data_drive_o = act.cs & act.oe;
    assign empty_n_o    = empty_n_q;

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !(act.rd && act.cs) |=> $stable(data_o)); // R3

    AST_LOAD_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        load |=> empty_n_o || (sel_s != $past(load_sel))); // R7

endmodule

// File: tb/tb_async_fifo_rdport.sv
module tb_async_fifo_rdport;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fifo_sel = 2'd0;
    logic        cs_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] data_o;
    logic        data_drive_o;
    logic        empty_n_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    async_fifo_rdport dut (
        .clk          (clk),
        .rst          (rst),
        .fifo_sel_i   (fifo_sel),
        .cs_n_i       (cs_n),
        .oe_n_i       (oe_n),
        .rd_n_i       (rd_n),
        .wr_en_i      (wr_en),
        .wr_sel_i     (wr_sel),
        .wr_data_i    (wr_data),
        .data_o       (data_o),
        .data_drive_o (data_drive_o),
        .empty_n_o    (empty_n_o)
    );

    task automatic chk(input string tag, input logic [31:0] actv, input logic [31:0] expv);
        n_chk++;
        if (actv !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, actv, expv, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          q[4][$];
    logic [4:0]  m_s1 = 5'b11100, m_s2 = 5'b11100; // {cs_n, oe_n, rd_n, sel}
    bit          m_rdp, m_csp;
    int          m_state;  // 0 idle, 1 word taken, 2 strobe on empty queue
    int          m_sel_l;
    logic [15:0] m_last;
    bit          m_empty_n;

    always @(posedge clk) begin
        #1;
        if (rst) begin
            for (int i = 0; i < 4; i++) q[i].delete();
            m_s1 = 5'b11100; m_s2 = 5'b11100;
            m_rdp = 0; m_csp = 0; m_state = 0; m_sel_l = 0;
            m_last = 16'd0; m_empty_n = 0;
        end else begin
            bit a_cs, a_rd, st, rel, wr_ok;
            int sel;
            a_cs = !m_s2[4];
            a_rd = !m_s2[2];
            sel  = int'(m_s2[1:0]);
            st   = a_rd && !m_rdp && a_cs && m_csp;
            rel  = !a_rd && m_rdp;
            wr_ok = wr_en && (q[wr_sel].size() < 16);
            m_empty_n = (q[sel].size() != 0);
            if (m_state != 0) begin
                if (rel) begin
                    if (m_state == 1) void'(q[m_sel_l].pop_front());
                    m_state = 0;
                end
            end else if (st) begin
                m_sel_l = sel;
                if (q[sel].size() > 0) begin
                    m_last  = q[sel][0][15:0];
                    m_state = 1;
                end else begin
                    m_state = 2;
                end
            end
            if (wr_ok) q[wr_sel].push_back(int'(wr_data));
            m_rdp = a_rd;
            m_csp = a_cs;
            m_s2  = m_s1;
            m_s1  = {cs_n, oe_n, rd_n, fifo_sel};
        end
        chk("R2 drive-enable", 32'(data_drive_o), 32'(!m_s2[4] && !m_s2[3]));
        chk("R5 shown word", 32'(data_o), 32'(m_last));
        chk("R9 empty flag", 32'(empty_n_o), 32'(m_empty_n));
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input bit tie);
        @(negedge clk);
        rd_n = 1'b0;
        if (tie) oe_n = 1'b0;
        idle(4);
        rd_n = 1'b1;
        if (tie) oe_n = 1'b1;
        idle(4);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 drive after reset", 32'(data_drive_o), 32'd0);
        chk("R1 word after reset", 32'(data_o), 32'd0);
        chk("R1 empty after reset", 32'(empty_n_o), 32'd0);

        for (int i = 0; i < 5; i++)  push(2'd0, 16'hA000 + 16'(i));
        for (int i = 0; i < 3; i++)  push(2'd1, 16'hB000 + 16'(i));
        for (int i = 0; i < 20; i++) push(2'd2, 16'hC000 + 16'(i));
        idle(3);

        @(negedge clk); fifo_sel = 2'd0; cs_n = 1'b0;
        idle(4);
        chk("R9 queue 0 holds words", 32'(empty_n_o), 32'd1);
        oe_n = 1'b0;
        idle(4);
        chk("R3 enable alone drives", 32'(data_drive_o), 32'd1);
        chk("R3 enable alone keeps old word", 32'(data_o), 32'd0);

        pulse(0);
        chk("R5 first word", 32'(data_o), 32'hA000);
        pulse(0);
        chk("R6 burst second", 32'(data_o), 32'hA001);
        pulse(0);
        chk("R6 burst third", 32'(data_o), 32'hA002);

        @(negedge clk); oe_n = 1'b1;
        idle(3);
        @(negedge clk); rd_n = 1'b0;
        idle(4);
        chk("R2 strobe without enable", 32'(data_drive_o), 32'd0);
        rd_n = 1'b1;
        idle(4);
        chk("R6 word loaded undriven", 32'(data_o), 32'hA003);
        oe_n = 1'b0;

        // strobe and chip select falling together
        cs_n = 1'b1;
        idle(4);
        cs_n = 1'b0; rd_n = 1'b0;
        idle(4);
        chk("R4 no load without prior select", 32'(data_o), 32'hA003);
        rd_n = 1'b1;
        idle(4);
        chk("R4 word still held", 32'(data_o), 32'hA003);
        pulse(0);
        chk("R4 no pointer move on rejected read", 32'(data_o), 32'hA004);
        chk("R7 queue 0 drained", 32'(empty_n_o), 32'd0);

        pulse(0);
        chk("R7 empty strobe keeps word", 32'(data_o), 32'hA004);
        push(2'd0, 16'hA0FF);
        idle(4);
        pulse(0);
        chk("R7 pointer not moved by empty strobe", 32'(data_o), 32'hA0FF);

        @(negedge clk); fifo_sel = 2'd1;
        idle(4);
        pulse(0);
        chk("R12 queue 1 head", 32'(data_o), 32'hB000);
        @(negedge clk); rd_n = 1'b0;
        idle(4);
        fifo_sel = 2'd2;
        idle(1);
        rd_n = 1'b1;
        idle(4);
        chk("R8 word from latched queue", 32'(data_o), 32'hB001);
        fifo_sel = 2'd1;
        idle(4);
        pulse(0);
        chk("R8 queue 1 advanced", 32'(data_o), 32'hB002);
        fifo_sel = 2'd2;
        idle(4);
        pulse(0);
        chk("R8 queue 2 untouched", 32'(data_o), 32'hC000);

        @(negedge clk); oe_n = 1'b1;
        idle(4);
        chk("R11 released before tied reads", 32'(data_drive_o), 32'd0);
        @(negedge clk); rd_n = 1'b0; oe_n = 1'b0;
        idle(4);
        chk("R11 tied pins drive", 32'(data_drive_o), 32'd1);
        chk("R11 tied pins show word", 32'(data_o), 32'hC001);
        rd_n = 1'b1; oe_n = 1'b1;
        idle(4);
        for (int i = 0; i < 14; i++) pulse(1);
        chk("R10 sixteenth word kept", 32'(data_o), 32'hC00F);
        chk("R10 overflow writes dropped", 32'(empty_n_o), 32'd0);
        pulse(1);
        chk("R7 tied strobe on empty queue", 32'(data_o), 32'hC00F);

        @(negedge clk); fifo_sel = 2'd3;
        idle(4);
        chk("R12 queue 3 never written", 32'(empty_n_o), 32'd0);

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule